// File: doc/BRIEF.md
# Serial Register Port with Selectable Readback Pin

This block is the slave side of a serial control port in front of an internal file of 32 byte-wide registers. A host frames each access by pulling the active-low enable `cs_n` low. It shifts in one 8-bit command, then one or more data bytes, all MSB first, on the rising edge of `sclk`. The command carries a direction flag, a byte-count field and a start address. Writes land in the register file. Reads return register contents bit by bit. The address steps by one after every byte.

Read data leaves the block on one of two paths, chosen by `mode_4w`. In three-wire mode it goes out on the shared data line, modelled here as `sdio_i`, `sdio_o` and `sdio_oe`. In four-wire mode it goes out on a dedicated output `sdo_o`/`sdo_oe`, and the shared line stays an input. Each output enable is a separate port, so the periods in which a pin is released can be observed directly. The port carries a bit-serial stream with no flow control. The host owns the clock, so there is no back-pressure. A host that stops clocking simply pauses the frame, and a host that raises `cs_n` abandons it.

Top module: `ssp_slave`

## Requirements
- R1: While `cs_n` is high both `sdio_oe` and `sdo_oe` are 0, and the bit and byte counters return to the start of a command, so a frame aborted at any point does not affect the next frame.
- R2: The first 8 bits of a frame form the command, MSB first: bit 7 is the direction (1 = read, 0 = write), bits 6:5 are the count field, and bits 4:0 are the start address.
- R3: A frame transfers (count field + 1) data bytes, MSB first. The address increases by one after each byte and wraps from 31 to 0.
- R4: A write byte is stored only once all 8 of its bits have been received. A byte cut short by `cs_n` rising leaves its register unchanged.
- R5: Bits clocked in after the last counted byte of a frame write nothing.
- R6: During the command bits, and throughout a write frame, neither `sdio_oe` nor `sdo_oe` is asserted.
- R7: In a read with `mode_4w` = 0, each data bit appears on `sdio_o` with `sdio_oe` = 1, and `sdo_oe` stays 0.
- R8: In a read with `mode_4w` = 1, each data bit appears on `sdo_o` with `sdo_oe` = 1, and `sdio_oe` stays 0.
- R9: After the falling edge that follows the last counted read bit, `sdo_o` is driven 0 with `sdo_oe` = 1 until `cs_n` rises when `mode_4w` = 1. When `mode_4w` = 0, `sdio_oe` drops to 0 at that edge instead.
- R10: Input bits are taken on the rising edge of `sclk`. Output bits change on the falling edge, so each read bit is valid from the falling edge that follows the previous rising edge.
- R11: `rst_n` low clears every register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| cs_n | input | 1 | Active-low frame enable; high resets the frame logic |
| mode_4w | input | 1 | 0: read data on shared line, 1: read data on dedicated output |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, drive enable |
| sdo_o | output | 1 | Dedicated read output value |
| sdo_oe | output | 1 | Dedicated read output drive enable |

## Verification
A bit counter that slips by one shifts read data by a bit position, which shows as a wrong bit within the first data byte of the next read. It also moves the commit point of writes, which a later read exposes. A wrong address or byte count shows up as the wrong register value, or as a misplaced low tail on `sdo_o`, in the very next read frame. A phase error shows as an output enable that is set or cleared one falling edge early or late. Every bit of every read frame is therefore compared with a model, together with both enables, at the falling edge where the bit must appear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ssp_frame_rx.sv
module ssp_frame_rx
  import ssp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 2,
  parameter int DATA_W = 8,
  localparam int CMD_W = 1 + LEN_W + ADDR_W,
  localparam int SH_W  = max2(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(SH_W)
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);
  phase_e            phase_q;
  logic [SH_W-1:0]   shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bytes_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic [SH_W-1:0]   sh_next;
  logic              cmd_last;
  logic              byte_last;

  assign sh_next   = {shreg_q[SH_W-2:0], sdi};
  assign cmd_last  = (cnt_q == CNT_W'(CMD_W - 1));
  assign byte_last = (cnt_q == CNT_W'(DATA_W - 1));

  // Frame logic: enable high holds everything at the start of a command
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      phase_q <= PH_CMD;
      shreg_q <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      bytes_q <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      shreg_q <= sh_next;
      case (phase_q)
        PH_CMD: begin
          if (cmd_last) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            rd_q    <= sh_next[CMD_W-1];
            len_q   <= sh_next[ADDR_W +: LEN_W];
            addr_q  <= sh_next[ADDR_W-1:0];
            bytes_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (byte_last) begin
            cnt_q  <= '0;
            addr_q <= addr_q + 1'b1;
            if (bytes_q == len_q) phase_q <= PH_TAIL;
            else bytes_q <= bytes_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign rd_o      = rd_q;
  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
  assign wr_en_o   = !cs_n && (phase_q == PH_DATA) && !rd_q && byte_last;
  assign wr_data_o = sh_next[DATA_W-1:0];

  AST_ADDR_STEP: assert property (@(posedge sclk) disable iff (cs_n)
    (phase_q == PH_DATA && byte_last) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R3
  AST_TAIL_STICKY: assert property (@(posedge sclk) disable iff (cs_n)
    (phase_q == PH_TAIL) |=> (phase_q == PH_TAIL)); // R5
endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g))) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

  AST_WR_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$isunknown(wr_data)); // R4
endmodule

// File: rtl/ssp_tx_drive.sv
module ssp_tx_drive
  import ssp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 2,
  parameter int DATA_W = 8,
  localparam int CMD_W = 1 + LEN_W + ADDR_W,
  localparam int SH_W  = max2(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(SH_W)
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mode_4w,
  input  phase_e            phase,
  input  logic              rd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe
);
  logic             bit_q;
  logic [CNT_W-1:0] sel;
  logic             in_data;
  logic             in_tail;

  assign sel     = CNT_W'(DATA_W - 1) - cnt;
  assign in_data = rd && (phase == PH_DATA);
  assign in_tail = rd && (phase == PH_TAIL);

  // Outputs move on the falling edge; enable high releases both pins at once
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bit_q   <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      bit_q   <= in_data ? rd_data[sel] : 1'b0;
      sdio_oe <= !mode_4w && in_data;
      sdo_oe  <= mode_4w && (in_data || in_tail);
    end
  end

  assign sdio_o = bit_q;
  assign sdo_o  = bit_q;

  AST_CMD_RELEASED: assert property (@(posedge sclk) disable iff (cs_n)
    (phase == PH_CMD) |-> (!sdio_oe && !sdo_oe)); // R6
  AST_TAIL_LOW: assert property (@(posedge sclk) disable iff (cs_n)
    (phase == PH_TAIL && sdo_oe) |-> !sdo_o); // R9
  AST_SHARED_IDLE_4W: assert property (@(posedge sclk) disable iff (cs_n)
    (mode_4w && $stable(mode_4w)) |-> !sdio_oe); // R8
endmodule

// File: rtl/ssp_slave.sv
module ssp_slave
  import ssp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 2,
  parameter int DATA_W = 8,
  localparam int CMD_W = 1 + LEN_W + ADDR_W,
  localparam int SH_W  = max2(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(SH_W)
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic mode_4w,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe
);
  phase_e            phase;
  logic              rd;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  ssp_frame_rx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) rx_i (
    .sclk(sclk), .cs_n(cs_n), .sdi(sdio_i),
    .phase_o(phase), .rd_o(rd), .addr_o(addr), .cnt_o(cnt),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  ssp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rf_i (
    .clk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
  );

  ssp_tx_drive #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) tx_i (
    .sclk(sclk), .cs_n(cs_n), .mode_4w(mode_4w), .phase(phase), .rd(rd),
    .cnt(cnt), .rd_data(rd_data),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  AST_WRITE_NO_DRIVE: assert property (@(posedge sclk) disable iff (cs_n)
    (phase != PH_CMD && !rd) |-> (!sdio_oe && !sdo_oe)); // R6
endmodule

// File: tb/ssp_slave_tb.sv
module ssp_slave_tb_top;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic mode_4w = 1'b0;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;

  int vectors = 0;
  int fails = 0;
  logic [7:0] model [32];
  string tag_over = "";

  always #2ns sclk = ~sclk;

  ssp_slave dut_i (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .mode_4w(mode_4w),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s%s act=%0h exp=%0h at %0t", req, tag_over, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [4:0] a0, input int j);
    logic [4:0] a;
    a = a0 + 5'((j / 8));
    return model[a][7 - (j % 8)];
  endfunction

  // Check both pins for the bit slot i of a frame (R6, R7, R8, R9, R10)
  task automatic check_slot(input bit rd, input int len, input logic [4:0] a0, input bit m4, input int i);
    int full, j;
    logic e;
    full = 8 * (len + 1);
    j = i - 8;
    if (i < 8 || !rd) begin
      chk(!sdio_oe && !sdo_oe, "R6 released", {6'd0, sdio_oe, sdo_oe}, 8'd0);
    end else if (j < full) begin
      e = exp_bit(a0, j);
      if (m4) chk(sdo_oe && !sdio_oe && sdo_o == e, "R8 R10 4w bit", {5'd0, sdo_oe, sdio_oe, sdo_o}, {5'd0, 2'b10, e});
      else    chk(sdio_oe && !sdo_oe && sdio_o == e, "R7 R10 3w bit", {5'd0, sdio_oe, sdo_oe, sdio_o}, {5'd0, 2'b10, e});
    end else begin
      if (m4) chk(sdo_oe && !sdio_oe && !sdo_o, "R9 4w tail", {5'd0, sdo_oe, sdio_oe, sdo_o}, 8'b100);
      else    chk(!sdio_oe && !sdo_oe, "R9 3w release", {6'd0, sdio_oe, sdo_oe}, 8'd0);
    end
  endtask

  task automatic frame(input bit rd, input int len, input logic [4:0] a0, input bit m4,
                       input logic [31:0] wd, input int total);
    logic [7:0] cmd;
    int full, done;
    cmd = {rd, 2'(len), a0};
    full = 8 * (len + 1);
    for (int i = 0; i < total; i++) begin
      @(negedge sclk); #1ns;
      if (i == 0) begin cs_n = 1'b0; mode_4w = m4; end
      check_slot(rd, len, a0, m4, i);
      if (i < 8) sdio_i = cmd[7 - i];
      else if (!rd && (i - 8) < 32) sdio_i = wd[31 - (i - 8)];
      else sdio_i = 1'($urandom);
    end
    @(negedge sclk); #1ns;
    check_slot(rd, len, a0, m4, total);
    cs_n = 1'b1;
    #1ns;
    chk(!sdio_oe && !sdo_oe, "R1 idle release", {6'd0, sdio_oe, sdo_oe}, 8'd0);
    if (!rd && total > 8) begin
      done = (total - 8) / 8;
      if (done > len + 1) done = len + 1;
      for (int b = 0; b < done; b++) model[a0 + 5'(b)] = wd[31 - 8*b -: 8];
    end
    @(negedge sclk);
  endtask

  task automatic full_frame(input bit rd, input int len, input logic [4:0] a0, input bit m4, input logic [31:0] wd);
    frame(rd, len, a0, m4, wd, 8 + 8 * (len + 1));
  endtask

  initial begin
    #400us;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    repeat (3) @(negedge sclk);
    #1ns;
    chk(!sdio_oe && !sdo_oe, "R1 reset release", {6'd0, sdio_oe, sdo_oe}, 8'd0);
    rst_n = 1'b1;
    @(negedge sclk);
    // R11: every register reads zero after reset
    tag_over = " R11";
    for (int k = 0; k < 8; k++) full_frame(1'b1, 3, 5'(4 * k), k[0], 32'd0);
    tag_over = "";
    // R2 R3: four-byte write across the wrap, read back in both modes
    full_frame(1'b0, 3, 5'd30, 1'b0, 32'hA55A_C381);
    full_frame(1'b1, 3, 5'd30, 1'b0, 32'd0);
    full_frame(1'b1, 3, 5'd30, 1'b1, 32'd0);
    full_frame(1'b1, 0, 5'd31, 1'b1, 32'd0);
    // R5: extra bits after a one-byte write must not reach address 6
    full_frame(1'b0, 0, 5'd6, 1'b0, 32'h3C00_0000);
    frame(1'b0, 0, 5'd5, 1'b0, 32'h96E7_0000, 8 + 24);
    full_frame(1'b1, 1, 5'd5, 1'b1, 32'd0);
    // R4: second byte cut after 4 bits stays unchanged
    full_frame(1'b0, 1, 5'd10, 1'b0, 32'h1122_0000);
    frame(1'b0, 1, 5'd10, 1'b0, 32'hF00F_0000, 8 + 12);
    full_frame(1'b1, 1, 5'd10, 1'b0, 32'd0);
    // R1: command aborted after 5 bits, next frame decodes cleanly
    frame(1'b0, 3, 5'd10, 1'b0, 32'hFFFF_FFFF, 5);
    full_frame(1'b1, 1, 5'd10, 1'b1, 32'd0);
    // R9: read aborted mid-byte then tail checks in a long overrun read
    frame(1'b1, 0, 5'd11, 1'b1, 32'd0, 8 + 3);
    frame(1'b1, 0, 5'd10, 1'b1, 32'd0, 8 + 8 + 6);
    frame(1'b1, 0, 5'd10, 1'b0, 32'd0, 8 + 8 + 6);
    // Constrained random mix
    for (int n = 0; n < 120; n++) begin
      bit rd, m4;
      int len, extra;
      logic [4:0] a;
      rd = 1'($urandom);
      m4 = 1'($urandom);
      len = int'($urandom_range(0, 3));
      a = 5'($urandom);
      extra = int'($urandom_range(0, 9));
      if (extra > 6) frame(rd, len, a, m4, $urandom, 8 + 8 * (len + 1) + extra);
      else if (extra == 0) frame(rd, len, a, m4, $urandom, int'($urandom_range(1, 8 + 8 * len + 7)));
      else full_frame(rd, len, a, m4, $urandom);
    end
    // R11: reset again clears the file
    rst_n = 1'b0;
    @(negedge sclk);
    rst_n = 1'b1;
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    tag_over = " R11";
    full_frame(1'b1, 3, 5'd10, 1'b1, 32'd0);
    tag_over = "";
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule